// File: doc/BRIEF.md
# Four-Convention LIFO Stack

This block is a synchronous last-in-first-out store built on an internal register-array memory that can map onto block RAM. A build-time parameter picks how the internal stack pointer behaves. The pointer can mark the next free slot ("empty" convention) or the last written slot ("full" convention). It can move toward address zero (descending) or toward the top address (ascending). All four choices give the same behaviour at the ports. Only the placement of words in memory differs.

Each clock, a single enable qualifies one operation. The operation is chosen by a direction input: 1 pushes the input word and 0 pops. A popped word is registered and appears on the data output one cycle after the pop. The output then holds until the next pop that takes effect. Full and empty status come from an occupancy count that runs from 0 up to the depth. A push into a full stack and a pop from an empty stack are both dropped, so the stack can neither overflow nor underflow. A synchronous active-high reset empties the stack and returns the pointer to the start value of its convention.

Top module: `lifo_stack`

## Requirements
- R1: With `en`=1 and `op_push`=1 while `full`=0, the word on `din` is stored. Later pops return stored words in reverse order of storage.
- R2: With `en`=1 and `op_push`=0 while `empty`=0, the most recently stored word not yet popped appears on `dout` one clock after the pop. `dout` keeps its value in every cycle without such a pop, pushes included.
- R3: A push while `full`=1 is ignored. `full` stays 1 and the stored contents are unchanged.
- R4: A pop while `empty`=1 is ignored. `empty` stays 1 and `dout` is unchanged.
- R5: With `en`=0 nothing changes, whatever `op_push` and `din` carry.
- R6: `empty`=1 exactly when no words are held and `full`=1 exactly when DEPTH words are held. Both update one clock after the operation that changes the count, and they are never high together.
- R7: A push followed in the next cycle by a pop returns the pushed word and leaves `empty`=1.
- R8: A pop while `full`=1 returns the last stored word and clears `full` in the next cycle.
- R9: The parameter MODE selects the pointer convention: 0 empty-descending, 1 empty-ascending, 2 full-descending, 3 full-ascending. All four give identical port behaviour for identical stimulus.
- R10: While `rst`=1 at a clock edge, the next state is `empty`=1, `full`=0, `dout`=0, with the pointer at its convention's start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Qualifies the operation this cycle |
| op_push | input | 1 | 1 = push, 0 = pop |
| din | input | DATA_W | Word to push |
| dout | output | DATA_W | Last popped word, registered |
| full | output | 1 | No free slot remains |
| empty | output | 1 | No word is held |

## Verification
The hardest situation to reach is the pointer wrap at the far end of memory. In the empty conventions the pointer runs past the last slot when the stack fills. In the full conventions it starts one position outside the array. A wrong wrap only shows up when the stack is filled to the brim, a push is refused, and every word is then drained. The bench runs four instances, one per convention, with a small depth and identical stimulus. It fills each to capacity, tries extra pushes, pops straight from full, and then drains to empty with further refused pops. Each output is compared against a single behavioural model.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

  // Pointer convention selected at build time
  typedef enum logic [1:0] {
    MODE_EMPTY_DESC = 2'd0,
    MODE_EMPTY_ASC  = 2'd1,
    MODE_FULL_DESC  = 2'd2,
    MODE_FULL_ASC   = 2'd3
  } stack_mode_e;

endpackage

// File: rtl/lifo_stack_ptr.sv
module lifo_stack_ptr
  import lifo_pkg::*;
#(
  parameter int          DEPTH = 256,
  parameter stack_mode_e MODE  = MODE_EMPTY_DESC,
  localparam int         AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_go,
  input  logic          pop_go,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr
);

  localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] step_up(input logic [AW-1:0] a);
    return (a == TOP_ADDR) ? '0 : a + 1'b1;
  endfunction

  function automatic logic [AW-1:0] step_down(input logic [AW-1:0] a);
    return (a == '0) ? TOP_ADDR : a - 1'b1;
  endfunction

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] push_next;
  logic [AW-1:0] pop_next;
  logic [AW-1:0] start_val;

  generate
    if (MODE == MODE_EMPTY_DESC) begin : g_ed
      // points at the free slot, grows toward zero
      assign start_val = TOP_ADDR;
      assign wr_addr   = ptr_q;
      assign push_next = step_down(ptr_q);
      assign rd_addr   = step_up(ptr_q);
      assign pop_next  = step_up(ptr_q);
    end else if (MODE == MODE_EMPTY_ASC) begin : g_ea
      // points at the free slot, grows toward the top
      assign start_val = '0;
      assign wr_addr   = ptr_q;
      assign push_next = step_up(ptr_q);
      assign rd_addr   = step_down(ptr_q);
      assign pop_next  = step_down(ptr_q);
    end else if (MODE == MODE_FULL_DESC) begin : g_fd
      // points at the last item; starts one past the top (wrapped to zero)
      assign start_val = '0;
      assign wr_addr   = step_down(ptr_q);
      assign push_next = step_down(ptr_q);
      assign rd_addr   = ptr_q;
      assign pop_next  = step_up(ptr_q);
    end else begin : g_fa
      // points at the last item; starts one below zero (wrapped to top)
      assign start_val = TOP_ADDR;
      assign wr_addr   = step_up(ptr_q);
      assign push_next = step_up(ptr_q);
      assign rd_addr   = ptr_q;
      assign pop_next  = step_down(ptr_q);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= start_val;
    end else if (push_go) begin
      ptr_q <= push_next;
    end else if (pop_go) begin
      ptr_q <= pop_next;
    end
  end

endmodule

// File: rtl/lifo_stack_level.sv
module lifo_stack_level #(
  parameter int  DEPTH = 256,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic push_go,
  input  logic pop_go,
  output logic full,
  output logic empty
);

  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic [CW-1:0] level_q;
  logic [CW-1:0] level_d;

  always_comb begin
    level_d = level_q;
    if (push_go) begin
      level_d = level_q + 1'b1;
    end else if (pop_go) begin
      level_d = level_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      full    <= 1'b0;
      empty   <= 1'b1;
    end else begin
      level_q <= level_d;
      full    <= (level_d == CAP);
      empty   <= (level_d == '0);
    end
  end

endmodule

// File: rtl/lifo_stack_ram.sv
module lifo_stack_ram #(
  parameter int  DATA_W = 16,
  parameter int  DEPTH  = 256,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] store [DEPTH];

  // write port, no reset so the array maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  // read port with enable; the output register takes a synchronous reset
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= store[raddr];
    end
  end

endmodule

// File: rtl/lifo_stack.sv
module lifo_stack
  import lifo_pkg::*;
#(
  parameter int          DATA_W = 16,
  parameter int          DEPTH  = 256,
  parameter stack_mode_e MODE   = MODE_EMPTY_DESC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              op_push,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              full,
  output logic              empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          push_go;
  logic          pop_go;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;

  // refused operations never reach the pointer, counter or memory
  assign push_go = en &  op_push & ~full;
  assign pop_go  = en & ~op_push & ~empty;

  lifo_stack_ptr #(.DEPTH(DEPTH), .MODE(MODE)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .push_go (push_go),
    .pop_go  (pop_go),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr)
  );

  lifo_stack_level #(.DEPTH(DEPTH)) u_level (
    .clk     (clk),
    .rst     (rst),
    .push_go (push_go),
    .pop_go  (pop_go),
    .full    (full),
    .empty   (empty)
  );

  lifo_stack_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (push_go),
    .waddr (wr_addr),
    .wdata (din),
    .re    (pop_go),
    .raddr (rd_addr),
    .rdata (dout)
  );

endmodule

// File: rtl/lifo_stack_chk.sv
module lifo_stack_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              op_push,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout,
  input logic              full,
  input logic              empty
);

  p_reset_state_r10: assert property (@(posedge clk)
    rst |=> (empty && !full && dout == '0));

  p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (full && en && op_push) |=> full);

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    (empty && en && !op_push) |=> (empty && $stable(dout)));

  p_dout_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(en && !op_push) |=> $stable(dout));

  p_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(full) && $stable(empty) && $stable(dout)));

  p_push_fills_r1: assert property (@(posedge clk) disable iff (rst)
    (en && op_push && !full) |=> !empty);

  p_pop_from_full_r8: assert property (@(posedge clk) disable iff (rst)
    (en && !op_push && full) |=> !full);

endmodule

bind lifo_stack lifo_stack_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .op_push (op_push),
  .din     (din),
  .dout    (dout),
  .full    (full),
  .empty   (empty)
);

// File: tb/tb_lifo_stack.sv
module tb_lifo_stack;
  import lifo_pkg::*;

  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int NMODE  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en = 1'b0;
  logic              op_push = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout_w [NMODE];
  logic              full_w [NMODE];
  logic              empty_w [NMODE];

  int n_checks = 0;
  int n_fail   = 0;

  // behavioural model
  logic [DATA_W-1:0] m_mem [DEPTH];
  int                m_cnt  = 0;
  logic [DATA_W-1:0] m_dout = '0;

  always #2 clk = ~clk;  // 250 MHz

  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    lifo_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MODE(stack_mode_e'(m))) dut (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .op_push (op_push),
      .din     (din),
      .dout    (dout_w[m]),
      .full    (full_w[m]),
      .empty   (empty_w[m])
    );
  end

  task automatic check_all(input string tag);
    for (int m = 0; m < NMODE; m++) begin
      n_checks++;
      if (dout_w[m] !== m_dout) begin
        n_fail++;
        $display("FAIL %s mode%0d dout actual=%h expected=%h", tag, m, dout_w[m], m_dout);
      end
      n_checks++;
      if (full_w[m] !== (m_cnt == DEPTH)) begin
        n_fail++;
        $display("FAIL %s mode%0d full actual=%b expected=%b", tag, m, full_w[m], m_cnt == DEPTH);
      end
      n_checks++;
      if (empty_w[m] !== (m_cnt == 0)) begin
        n_fail++;
        $display("FAIL %s mode%0d empty actual=%b expected=%b", tag, m, empty_w[m], m_cnt == 0);
      end
    end
  endtask

  // drive at falling edge, let one rising edge pass, sample at next falling edge
  task automatic step(input logic e, input logic p, input logic [DATA_W-1:0] d, input string tag);
    en = e; op_push = p; din = d;
    @(posedge clk);
    if (e && p && m_cnt < DEPTH) begin
      m_mem[m_cnt] = d;
      m_cnt++;
    end else if (e && !p && m_cnt > 0) begin
      m_cnt--;
      m_dout = m_mem[m_cnt];
    end
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_cnt = 0; m_dout = '0;
    check_all("R10 reset");
  endtask

  task automatic t_reset();
    do_reset();
  endtask

  task automatic t_push_then_pop();  // R7
    step(1'b1, 1'b1, 16'hA5C3, "R7 push");
    step(1'b1, 1'b0, 16'h0000, "R7 pop");
  endtask

  task automatic t_fill_drain();  // R1 R6 R9
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b1, DATA_W'(16'h1100 + i), "R1 fill");
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, '0, "R1 R9 drain");
  endtask

  task automatic t_overflow();  // R3 R8
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b1, DATA_W'(16'h2200 + i), "R6 fill");
    step(1'b1, 1'b1, 16'hDEAD, "R3 push while full");
    step(1'b1, 1'b1, 16'hBEEF, "R3 push while full");
    step(1'b1, 1'b0, '0, "R8 pop from full");
    step(1'b1, 1'b1, 16'h3333, "R3 refill");
    step(1'b1, 1'b0, '0, "R8 pop from full");
    for (int i = 0; i < DEPTH - 1; i++) step(1'b1, 1'b0, '0, "R3 drain");
  endtask

  task automatic t_underflow();  // R4
    step(1'b1, 1'b0, '0, "R4 pop while empty");
    step(1'b1, 1'b0, '0, "R4 pop while empty");
    step(1'b1, 1'b1, 16'h0F0F, "R4 push after");
    step(1'b1, 1'b0, '0, "R4 pop after");
  endtask

  task automatic t_disable();  // R5 R2
    step(1'b1, 1'b1, 16'h4444, "R5 push");
    step(1'b1, 1'b1, 16'h5555, "R5 push");
    step(1'b0, 1'b1, 16'h9999, "R5 disabled push");
    step(1'b0, 1'b0, 16'h0000, "R5 disabled pop");
    step(1'b1, 1'b0, '0, "R5 pop");
    step(1'b1, 1'b1, 16'h7777, "R2 hold across push");
    step(1'b0, 1'b0, '0, "R2 hold idle");
    step(1'b1, 1'b0, '0, "R2 pop");
    step(1'b1, 1'b0, '0, "R2 pop");
  endtask

  task automatic t_mixed();  // R1 R9 pseudo-random
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3] | lfsr[7], lfsr[0] ^ lfsr[5], lfsr, "R1 R9 mixed");
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_push_then_pop();
    t_fill_drain();
    t_overflow();
    t_underflow();
    t_disable();
    t_mixed();
    t_push_then_pop();
    do_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule